// File: doc/BRIEF.md
# S/PDIF Subframe Biphase Encoder

This block turns one stereo pair per frame into a self-clocking serial audio line. For each frame it takes a 24-bit left sample and a 24-bit right sample, each paired with one channel-status bit. It builds two 32-slot subframes from them, left first as channel A and then right as channel B. A slot carries a synchronising preamble, audio, validity, user, channel-status or parity information. The whole frame is then driven as a biphase-mark coded line.

The block runs from a clock at 256 times the sample rate. Every line cell is held for `CLKS_PER_CELL` clocks, so a frame is 128 cells long. A frame counter running from 0 to 191 selects the block-start preamble and is also driven out. An external table can therefore present the channel-status bits for the next frame. In the last clock of every frame the block raises `loadReq` and captures the sample and status inputs in that cycle. Those values are sent in the following frame, whose index is `frameIdx + 1` modulo 192.

Top module: `spdif_subframe_encoder`

## Requirements
- R1: Each line cell is held for CLKS_PER_CELL (default 2) clocks. A frame is 128 cells, and `loadReq` is high for exactly one clock per frame, in the frame's last clock.
- R2: While `rstN` is low, `lineOut` is 0 and `frameIdx` is 191. `loadReq` is high in the first clock after release, and the first frame sent is frame 0.
- R3: Cells 0–63 of a frame form subframe A (left) and cells 64–127 form subframe B (right). Slot k of a subframe occupies its cells 2k and 2k+1. Slots 0–3 carry the preamble and slots 4–27 carry the sample, least significant bit in slot 4. Slot 28 (validity) and slot 29 (user) are always 0.
- R4: Slot 31 carries a parity bit. It makes the count of ones across slots 4–31 even.
- R5: With the previous cell low, the eight preamble cells in time order are 11101000 for channel A of frame 0, 11100010 for channel A of every other frame, and 11100100 for every channel B.
- R6: If the cell before a preamble was high, the preamble is sent inverted. The line therefore always changes level at the first preamble cell.
- R7: In slots 4–31 the first cell of a slot is the inverse of the cell before it. The second cell repeats the first for a 0 and inverts it for a 1.
- R8: `frameIdx` counts frames 0 to 191 and wraps to 0. Slot 30 of each subframe carries the status bit captured for that frame.
- R9: Sample and status inputs in any cycle where `loadReq` is low have no effect on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 256 times the sample rate |
| rstN | input | 1 | Active-low synchronous reset |
| leftSample | input | 24 | Channel A sample, two's complement |
| rightSample | input | 24 | Channel B sample, two's complement |
| leftStatus | input | 1 | Channel-status bit for channel A of the next frame |
| rightStatus | input | 1 | Channel-status bit for channel B of the next frame |
| loadReq | output | 1 | High in the clock whose inputs are captured |
| frameIdx | output | 8 | Index of the frame now on the line |
| lineOut | output | 1 | Biphase-mark coded serial output |

## Verification
At the clock edge that opens cell 0, the input capture, the frame-counter step and the block-start choice all happen together. The preamble polarity decision, which depends on the final parity-coded cell of the previous frame, falls in that same edge. The bench runs past the 192-frame wrap so that this coincidence also meets the counter's return to 0. It feeds all-ones, all-zeros, extreme and random samples, so that the final cell level is exercised for both parity values. A behavioural model builds every frame cell by cell from the captured inputs and is compared with the line on every clock. Junk inputs driven outside the load cycle must leave the line unchanged.

// File: rtl/spdif_enc_pkg.sv
package spdif_enc_pkg;
  localparam int SAMPLE_W        = 24;
  localparam int SLOTS_PER_SUB   = 32;
  localparam int PRE_SLOTS       = 4;
  localparam int CELLS_PER_SLOT  = 2;
  localparam int SUBS_PER_FRAME  = 2;
  localparam int CELLS_PER_FRAME = SUBS_PER_FRAME * SLOTS_PER_SUB * CELLS_PER_SLOT;
  localparam int CELL_W          = $clog2(CELLS_PER_FRAME);
  localparam int SLOT_W          = $clog2(SLOTS_PER_SUB);
  localparam int PRE_CELL_W      = $clog2(PRE_SLOTS * CELLS_PER_SLOT);
  localparam int PAYLOAD_W       = SLOTS_PER_SUB - PRE_SLOTS;

  // preamble cell patterns, first cell in the MSB, for a low preceding cell
  localparam logic [7:0] PRE_BLOCK = 8'b11101000;
  localparam logic [7:0] PRE_CHA   = 8'b11100010;
  localparam logic [7:0] PRE_CHB   = 8'b11100100;

  typedef struct packed {
    logic              cellEnd;     // last clock of the current cell
    logic              load;        // capture inputs for the next frame
    logic              blockStart;  // frame holding nextCell has index 0
    logic [CELL_W-1:0] nextCell;    // cell index that starts after cellEnd
  } encStrobe_t;
endpackage

// File: rtl/spdif_enc_control.sv
module spdif_enc_control
  import spdif_enc_pkg::*;
#(
  parameter int CLKS_PER_CELL    = 2,
  parameter int FRAMES_PER_BLOCK = 192,
  parameter int FRAME_W          = $clog2(FRAMES_PER_BLOCK)
) (
  input  logic               clk,
  input  logic               rstN,
  output encStrobe_t         strobe,
  output logic [FRAME_W-1:0] frameIdx
);
  localparam int DIV_W = (CLKS_PER_CELL > 1) ? $clog2(CLKS_PER_CELL) : 1;
  localparam logic [DIV_W-1:0]   LAST_DIV   = DIV_W'(CLKS_PER_CELL - 1);
  localparam logic [CELL_W-1:0]  LAST_CELL  = CELL_W'(CELLS_PER_FRAME - 1);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES_PER_BLOCK - 1);

  logic [DIV_W-1:0]   divQ;
  logic [CELL_W-1:0]  cellQ;
  logic [FRAME_W-1:0] frameQ;
  logic [FRAME_W-1:0] frameNext;
  logic               cellEnd;
  logic               frameEnd;

  assign cellEnd   = (divQ == LAST_DIV);
  assign frameEnd  = cellEnd && (cellQ == LAST_CELL);
  assign frameNext = (frameQ == LAST_FRAME) ? '0 : frameQ + 1'b1;

  // reset parks the counters on the last clock of a virtual frame 191
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ   <= LAST_DIV;
      cellQ  <= LAST_CELL;
      frameQ <= LAST_FRAME;
    end else begin
      divQ <= cellEnd ? '0 : divQ + 1'b1;
      if (cellEnd) cellQ <= cellQ + 1'b1;
      if (frameEnd) frameQ <= frameNext;
    end
  end

  always_comb begin
    strobe.cellEnd    = cellEnd;
    strobe.load       = frameEnd;
    strobe.nextCell   = cellQ + 1'b1;
    strobe.blockStart = (cellQ == LAST_CELL) ? (frameNext == '0) : (frameQ == '0);
  end

  assign frameIdx = frameQ;

  // R8: counter never leaves its range
  a_r8_frame_range: assert property (@(posedge clk) disable iff (!rstN)
    frameIdx <= LAST_FRAME);

  // R8: each load is followed by a one-step advance with wrap
  a_r8_frame_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> frameIdx == (($past(frameIdx) == LAST_FRAME) ? '0 : $past(frameIdx) + 1'b1));

  // R1: load is a single-clock pulse
  a_r1_load_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !strobe.load);
endmodule

// File: rtl/spdif_enc_datapath.sv
module spdif_enc_datapath
  import spdif_enc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  encStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                leftStatus,
  input  logic                rightStatus,
  output logic                lineOut
);
  logic [SUBS_PER_FRAME-1:0][SAMPLE_W-1:0]  sampleIn;
  logic [SUBS_PER_FRAME-1:0]                statusIn;
  logic [SUBS_PER_FRAME-1:0][PAYLOAD_W-1:0] payload;

  assign sampleIn = {rightSample, leftSample};
  assign statusIn = {rightStatus, leftStatus};

  // one held sample and status bit per subframe, payload word = slots 4..31
  for (genvar ch = 0; ch < SUBS_PER_FRAME; ch++) begin : g_chan
    logic [SAMPLE_W-1:0] heldSample;
    logic                heldStatus;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        heldSample <= '0;
        heldStatus <= 1'b0;
      end else if (strobe.load) begin
        heldSample <= sampleIn[ch];
        heldStatus <= statusIn[ch];
      end
    end

    // parity, status, user = 0, validity = 0, audio LSB first
    assign payload[ch] = {^{heldStatus, heldSample}, heldStatus, 1'b0, 1'b0, heldSample};
  end

  logic                  lineQ;
  logic                  preInv;
  logic                  subB;
  logic [SLOT_W-1:0]     slotIdx;
  logic [SLOT_W-1:0]     payIdx;
  logic [PRE_CELL_W-1:0] preCell;
  logic                  inPreamble;
  logic                  preStart;
  logic                  payBit;
  logic [7:0]            prePattern;
  logic                  invNow;
  logic                  nextLevel;

  assign subB       = strobe.nextCell[CELL_W-1];
  assign slotIdx    = strobe.nextCell[CELL_W-2:1];
  assign preCell    = strobe.nextCell[PRE_CELL_W-1:0];
  assign inPreamble = (strobe.nextCell[CELL_W-2:PRE_CELL_W] == '0);
  assign preStart   = inPreamble && (preCell == '0);
  assign payIdx     = slotIdx - SLOT_W'(PRE_SLOTS);
  assign payBit     = payload[subB][payIdx];

  always_comb begin
    if (subB)                   prePattern = PRE_CHB;
    else if (strobe.blockStart) prePattern = PRE_BLOCK;
    else                        prePattern = PRE_CHA;
    invNow = preStart ? lineQ : preInv;
    if (inPreamble)               nextLevel = prePattern[~preCell] ^ invNow;
    else if (strobe.nextCell[0])  nextLevel = lineQ ^ payBit;
    else                          nextLevel = ~lineQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ  <= 1'b0;
      preInv <= 1'b0;
    end else if (strobe.cellEnd) begin
      lineQ <= nextLevel;
      if (preStart) preInv <= lineQ;
    end
  end

  assign lineOut = lineQ;

  // R1: the line only moves at cell ends
  a_r1_cell_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cellEnd |=> $stable(lineOut));

  // R6: level change at the first preamble cell
  a_r6_preamble_edge: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cellEnd && preStart) |=> lineOut != $past(lineOut));

  // R7: level change at every coded slot boundary
  a_r7_slot_edge: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cellEnd && !inPreamble && !strobe.nextCell[0]) |=> lineOut != $past(lineOut));

  // R4: even parity returns each subframe to the level its preamble ended on (low)
  a_r4_even_close: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cellEnd && preStart) |-> !lineOut);
endmodule

// File: rtl/spdif_subframe_encoder.sv
module spdif_subframe_encoder
  import spdif_enc_pkg::*;
#(
  parameter int CLKS_PER_CELL    = 2,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [SAMPLE_W-1:0]                 leftSample,
  input  logic [SAMPLE_W-1:0]                 rightSample,
  input  logic                                leftStatus,
  input  logic                                rightStatus,
  output logic                                loadReq,
  output logic [$clog2(FRAMES_PER_BLOCK)-1:0] frameIdx,
  output logic                                lineOut
);
  localparam int FRAME_W = $clog2(FRAMES_PER_BLOCK);

  encStrobe_t strobe;

  spdif_enc_control #(
    .CLKS_PER_CELL   (CLKS_PER_CELL),
    .FRAMES_PER_BLOCK(FRAMES_PER_BLOCK),
    .FRAME_W         (FRAME_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .frameIdx(frameIdx)
  );

  spdif_enc_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .leftSample (leftSample),
    .rightSample(rightSample),
    .leftStatus (leftStatus),
    .rightStatus(rightStatus),
    .lineOut    (lineOut)
  );

  assign loadReq = strobe.load;
endmodule

// File: tb/sim_spdif_subframe_encoder.sv
module sim_spdif_subframe_encoder;
  localparam int CPC        = 2;
  localparam int CELLS      = 128;
  localparam int FRAMES     = 192;
  localparam int RUN_FRAMES = 200;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] leftSample = '0;
  logic [23:0] rightSample = '0;
  logic        leftStatus = 1'b0;
  logic        rightStatus = 1'b0;
  logic        loadReq;
  logic [7:0]  frameIdx;
  logic        lineOut;

  always #2 clk = ~clk;

  spdif_subframe_encoder u0 (
    .clk(clk), .rstN(rstN),
    .leftSample(leftSample), .rightSample(rightSample),
    .leftStatus(leftStatus), .rightStatus(rightStatus),
    .loadReq(loadReq), .frameIdx(frameIdx), .lineOut(lineOut)
  );

  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;
  bit    expQ[$];
  string tagQ[$];
  bit    csTab[2][FRAMES];
  bit    modelLevel;
  int    modelFrame;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic pushCell(bit lvl, string tag);
    repeat (CPC) begin
      expQ.push_back(lvl);
      tagQ.push_back(tag);
    end
    modelLevel = lvl;
  endtask

  function automatic logic [23:0] pickSample(int f, int ch);
    case (f % 6)
      0: return 24'($urandom());
      1: return 24'h000000;
      2: return 24'hFFFFFF;
      3: return ch ? 24'h7FFFFF : 24'h800000;
      4: return ch ? 24'h5A5A5A : 24'hA5A5A5;
      default: return 24'($urandom()) | 24'h000001;
    endcase
  endfunction

  // behavioural frame builder: expected line level for every clock of one frame
  task automatic buildFrame(int f, logic [23:0] sa, logic [23:0] sb, bit ca, bit cb);
    for (int ch = 0; ch < 2; ch++) begin
      bit [31:0] slots;
      bit [7:0]  pat;
      bit        inv;
      int        ones;
      slots = '0;
      slots[27:4] = ch ? sb : sa;
      slots[30] = ch ? cb : ca;
      ones = 0;
      for (int s = 4; s <= 30; s++) ones += slots[s];
      slots[31] = ones[0];
      if (ch == 1)      pat = 8'b11100100;
      else if (f == 0)  pat = 8'b11101000;
      else              pat = 8'b11100010;
      inv = modelLevel;
      for (int i = 0; i < 8; i++) pushCell(pat[7-i] ^ inv, (i == 0) ? "R6" : "R5");
      for (int s = 4; s < 32; s++) begin
        pushCell(!modelLevel, "R7");
        if (s == 31)      pushCell(modelLevel ^ slots[s], "R4");
        else if (s == 30) pushCell(modelLevel ^ slots[s], "R8");
        else              pushCell(modelLevel ^ slots[s], "R3 R9");
      end
    end
  endtask

  initial begin
    for (int i = 0; i < FRAMES; i++) begin
      csTab[0][i] = 1'($urandom());
      csTab[1][i] = 1'($urandom());
    end
    // R2: reset state
    repeat (4) begin
      @(negedge clk);
      check(lineOut == 1'b0, "R2", "lineOut in reset", int'(lineOut), 0);
      check(frameIdx == 8'd191, "R2", "frameIdx in reset", int'(frameIdx), 191);
    end
    rstN = 1'b1;
    modelLevel = 1'b0;
    modelFrame = FRAMES - 1;
    for (int cyc = 0; cyc < RUN_FRAMES * CELLS * CPC; cyc++) begin
      bit expLoad;
      if (cyc > 0) begin
        bit    e;
        string t;
        @(negedge clk);
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(lineOut == e, t, "lineOut", int'(lineOut), int'(e));
      end
      expLoad = (cyc % (CELLS * CPC)) == 0;
      check(loadReq == expLoad, (cyc == 0) ? "R2" : "R1", "loadReq", int'(loadReq), int'(expLoad));
      check(int'(frameIdx) == modelFrame, "R8", "frameIdx", int'(frameIdx), modelFrame);
      if (expLoad) begin
        int nf;
        nf = (modelFrame + 1) % FRAMES;
        leftSample  = pickSample(nf, 0);
        rightSample = pickSample(nf, 1);
        leftStatus  = csTab[0][nf];
        rightStatus = csTab[1][nf];
        buildFrame(nf, leftSample, rightSample, leftStatus, rightStatus);
        modelFrame = nf;
      end else begin
        // R9: junk outside the load cycle must not reach the line
        leftSample  = 24'($urandom());
        rightSample = 24'($urandom());
        leftStatus  = 1'($urandom());
        rightStatus = 1'($urandom());
      end
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, RUN_FRAMES * CELLS * CPC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule